// File: doc/BRIEF.md
# Variable-Pulse-Width Bus Frame Error Checker

This block sits behind the symbol timer of a variable-pulse-width serial bus receiver. It is given one classified symbol at a time: the measured width of a line period in clock ticks, and the line level (1 = active, 0 = passive) held during that period. From these symbols it follows a frame through start-of-frame, data bits, end-of-data, the normalisation bit that opens an in-frame response, the response bytes and end-of-frame. It puts each completed byte on its output.

The block sorts every framing fault into one of three outcomes. Some faults raise a sticky ERR flag. Some raise a sticky CRC flag. Some are dropped without any flag. After an abort it enters a wait-for-idle state and discards every symbol except noise until the bus has been passive for at least the end-of-frame width.

An echo-fail input from the transmit path is merged into the ERR flag. A host-driven `nxt` input forces the wait-for-idle state without raising a flag.

Top module: `vpw_frame_checker`

## Requirements
- R1: After reset both flags are 0 and `rx_valid` is 0. The block starts in wait-for-idle, so a frame that begins before the first passive symbol of at least EOF_MIN ticks produces no bytes and no flag.
- R2: A symbol shorter than SHORT_MIN ticks is noise. It sets ERR in every state, wait-for-idle included, and aborts the frame.
- R3: Bit encoding: an active short symbol is 1, an active long symbol is 0, a passive short symbol is 0 and a passive long symbol is 1. Bits are assembled MSB first. Each eighth bit of the body or the response gives a one-cycle `rx_valid` with the byte on `rx_byte`. `rx_ifr` is 1 for response bytes and 0 for body bytes.
- R4: Inside a frame, an active symbol that is neither a short nor a long data width nor a Break sets ERR.
- R5: An end-of-data reached after a bit count that is not a multiple of 8 sets ERR and leaves CRC clear.
- R6: In idle, an active symbol that is not of SOF width sets ERR. After end-of-data, an active symbol whose width fits neither the short nor the long class (a bad normalisation bit) sets ERR.
- R7: A frame with no response whose closing passive period is at least EOF_MIN but below IFS_MIN ticks, followed directly by an SOF, sets ERR on that SOF.
- R8: An SOF followed directly by end-of-data (zero bytes) sets CRC and leaves ERR clear.
- R9: The body check byte is the complement of a CRC-8 with polynomial 0x1D (x^8+x^4+x^3+x^2+1) and initial value 0xFF. Every byte is shifted in MSB first. A correct frame leaves the residue 0xC4. A bad residue sets CRC, and any response that follows yields no bytes.
- R10: A normalisation bit of long width opens a response that carries its own check byte, and a bad residue there sets CRC. A normalisation bit of short width opens a response with no check byte.
- R11: Wait-for-idle is entered after reset, after `nxt`, after any ERR or CRC event, after a Break, and after end-of-data of a response. It then discards symbols other than noise with no flag and no bytes. A passive symbol of at least EOF_MIN ends it. A second normalisation bit after a response is dropped this way.
- R12: A one-cycle `echo_fail` pulse sets ERR and aborts the frame.
- R13: Each flag stays set until its clear input is pulsed. A new event in the same cycle as the clear keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | One-cycle pulse: a symbol is presented |
| sym_level | input | 1 | Line level of the symbol, 1 = active |
| sym_width | input | WW | Measured symbol width in clock ticks |
| echo_fail | input | 1 | Transmit edge not seen on the receive line |
| nxt | input | 1 | Host request to drop the frame and wait for idle |
| clr_err | input | 1 | Clears the ERR flag |
| clr_crc | input | 1 | Clears the CRC flag |
| rx_byte | output | 8 | Last completed byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |
| rx_ifr | output | 1 | The strobed byte belongs to an in-frame response |
| err_flag | output | 1 | Sticky ERR status |
| crc_flag | output | 1 | Sticky CRC status |

## Verification
The hardest condition to reach from the ports is the silent-discard path. This is the stretch after a response's end-of-data, or after a bad body check byte, in which a second normalisation bit and a whole byte arrive and must leave no trace. The stimulus first builds a complete, correctly checked frame and response, then appends a legal-looking second response. The scoreboard queue holds no entry for those bytes, so any strobe from them is reported as unexpected. A clean frame sent afterwards shows that the block returned to idle and not to a stuck state. The TV4 check is reached in a similar way: a valid frame is closed with a passive period between the EOF and IFS limits, and an SOF follows it at once.

// File: rtl/vpw_chk_pkg.sv
package vpw_chk_pkg;

  typedef enum logic [2:0] {
    SC_NOISE, SC_SHORT, SC_LONG, SC_SOF, SC_EOD, SC_EOF, SC_BRK, SC_BAD
  } sym_cls_t;

  typedef enum logic [2:0] {
    FS_WAIT, FS_IDLE, FS_BODY, FS_POSTEOD, FS_RESP
  } frm_state_t;

  localparam logic [7:0] CRC_POLY = 8'h1D;
  localparam logic [7:0] CRC_INIT = 8'hFF;
  localparam logic [7:0] CRC_GOOD = 8'hC4;

  // one-bit step of the check-byte register, MSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
    logic fb;
    fb = c[7] ^ b;
    return {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
  endfunction

  // data bit carried by a short/long symbol at a given level
  function automatic logic sym_bit(input logic level, input logic is_long);
    return level ^ is_long;
  endfunction

endpackage

// File: rtl/vpw_sym_class.sv
module vpw_sym_class
  import vpw_chk_pkg::*;
#(
  parameter int WW        = 10,
  parameter int SHORT_MIN = 34,
  parameter int SHORT_MAX = 96,
  parameter int LONG_MIN  = 97,
  parameter int LONG_MAX  = 163,
  parameter int SOF_MIN   = 164,
  parameter int SOF_MAX   = 239,
  parameter int EOD_MIN   = 164,
  parameter int EOD_MAX   = 238,
  parameter int EOF_MIN   = 239,
  parameter int BRK_MIN   = 240
) (
  input  logic [WW-1:0] width,
  input  logic          level,
  output sym_cls_t      cls,
  output logic          bit_val
);

  localparam logic [WW-1:0] T_SMIN = WW'(SHORT_MIN);
  localparam logic [WW-1:0] T_SMAX = WW'(SHORT_MAX);
  localparam logic [WW-1:0] T_LMIN = WW'(LONG_MIN);
  localparam logic [WW-1:0] T_LMAX = WW'(LONG_MAX);
  localparam logic [WW-1:0] T_FMIN = WW'(SOF_MIN);
  localparam logic [WW-1:0] T_FMAX = WW'(SOF_MAX);
  localparam logic [WW-1:0] T_DMIN = WW'(EOD_MIN);
  localparam logic [WW-1:0] T_DMAX = WW'(EOD_MAX);
  localparam logic [WW-1:0] T_EMIN = WW'(EOF_MIN);
  localparam logic [WW-1:0] T_BMIN = WW'(BRK_MIN);

  always_comb begin
    cls = SC_BAD;
    if (width < T_SMIN)                          cls = SC_NOISE;
    else if (width <= T_SMAX)                    cls = SC_SHORT;
    else if (width >= T_LMIN && width <= T_LMAX) cls = SC_LONG;
    else if (level) begin
      if (width >= T_FMIN && width <= T_FMAX)    cls = SC_SOF;
      else if (width >= T_BMIN)                  cls = SC_BRK;
    end else begin
      if (width >= T_DMIN && width <= T_DMAX)    cls = SC_EOD;
      else if (width >= T_EMIN)                  cls = SC_EOF;
    end
  end

  assign bit_val = sym_bit(level, cls == SC_LONG);

endmodule

// File: rtl/vpw_byte_shift.sv
module vpw_byte_shift
  import vpw_chk_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          bit_en,
  input  logic          bit_val,
  output logic [BW-1:0] byte_out,
  output logic          byte_stb,
  output logic [7:0]    crc_res,
  output logic          aligned,
  output logic          empty
);

  localparam int PW = $clog2(BW);
  localparam logic [PW-1:0] LAST = PW'(BW - 1);

  logic [BW-2:0] sh_q;
  logic [PW-1:0] phase_q;
  logic          nonempty_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q       <= '0;
      phase_q    <= '0;
      nonempty_q <= 1'b0;
      crc_res    <= CRC_INIT;
      byte_out   <= '0;
      byte_stb   <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      if (start) begin
        phase_q    <= '0;
        nonempty_q <= 1'b0;
        crc_res    <= CRC_INIT;
      end else if (bit_en) begin
        sh_q       <= {sh_q[BW-3:0], bit_val};
        crc_res    <= crc8_step(crc_res, bit_val);
        nonempty_q <= 1'b1;
        if (phase_q == LAST) begin
          byte_out <= {sh_q, bit_val};
          byte_stb <= 1'b1;
          phase_q  <= '0;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end

  assign aligned = (phase_q == '0);
  assign empty   = !nonempty_q;

  // R3
  stb_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> aligned && !empty);

  // R8
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> empty && aligned && !byte_stb);

endmodule

// File: rtl/vpw_frame_checker.sv
module vpw_frame_checker
  import vpw_chk_pkg::*;
#(
  parameter int WW        = 10,
  parameter int SHORT_MIN = 34,
  parameter int SHORT_MAX = 96,
  parameter int LONG_MIN  = 97,
  parameter int LONG_MAX  = 163,
  parameter int SOF_MIN   = 164,
  parameter int SOF_MAX   = 239,
  parameter int EOD_MIN   = 164,
  parameter int EOD_MAX   = 238,
  parameter int EOF_MIN   = 239,
  parameter int BRK_MIN   = 240,
  parameter int IFS_MIN   = 280
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sym_valid,
  input  logic          sym_level,
  input  logic [WW-1:0] sym_width,
  input  logic          echo_fail,
  input  logic          nxt,
  input  logic          clr_err,
  input  logic          clr_crc,
  output logic [7:0]    rx_byte,
  output logic          rx_valid,
  output logic          rx_ifr,
  output logic          err_flag,
  output logic          crc_flag
);

  localparam logic [WW-1:0] T_IFS = WW'(IFS_MIN);

  sym_cls_t   cls;
  logic       bit_val;
  frm_state_t st_q, st_n;
  logic       gap_short_q, gap_short_n;
  logic       resp_crc_q, resp_crc_n;
  logic       last_resp_q;

  // named internal events
  logic       err_evt, crc_evt, bit_en, shift_start, ev_noise;
  logic [7:0] crc_res;
  logic       aligned, empty;
  frm_state_t abort_to;

  vpw_sym_class #(
    .WW(WW), .SHORT_MIN(SHORT_MIN), .SHORT_MAX(SHORT_MAX),
    .LONG_MIN(LONG_MIN), .LONG_MAX(LONG_MAX),
    .SOF_MIN(SOF_MIN), .SOF_MAX(SOF_MAX),
    .EOD_MIN(EOD_MIN), .EOD_MAX(EOD_MAX),
    .EOF_MIN(EOF_MIN), .BRK_MIN(BRK_MIN)
  ) cls_i (
    .width(sym_width), .level(sym_level), .cls(cls), .bit_val(bit_val)
  );

  vpw_byte_shift #(.BW(8)) shift_i (
    .clk(clk), .rst_n(rst_n), .start(shift_start), .bit_en(bit_en),
    .bit_val(bit_val), .byte_out(rx_byte), .byte_stb(rx_valid),
    .crc_res(crc_res), .aligned(aligned), .empty(empty)
  );

  assign ev_noise = sym_valid && (cls == SC_NOISE);
  // an abort on a symbol that already spans end-of-frame finds the bus idle
  assign abort_to = (cls == SC_EOF) ? FS_IDLE : FS_WAIT;

  always_comb begin
    st_n        = st_q;
    gap_short_n = gap_short_q;
    resp_crc_n  = resp_crc_q;
    err_evt     = 1'b0;
    crc_evt     = 1'b0;
    bit_en      = 1'b0;
    shift_start = 1'b0;
    if (nxt) begin
      st_n = FS_WAIT;
    end else if (echo_fail) begin
      err_evt = 1'b1;
      st_n    = FS_WAIT;
    end else if (sym_valid) begin
      if (cls == SC_NOISE) begin
        err_evt = 1'b1;
        st_n    = FS_WAIT;
      end else begin
        unique case (st_q)
          FS_WAIT: begin
            if (cls == SC_EOF) begin
              st_n        = FS_IDLE;
              gap_short_n = 1'b0;
            end
          end
          FS_IDLE: begin
            if (!sym_level) begin
              gap_short_n = 1'b0;
            end else if (cls == SC_BRK) begin
              st_n = FS_WAIT;
            end else if (cls == SC_SOF && !gap_short_q) begin
              st_n        = FS_BODY;
              shift_start = 1'b1;
            end else begin
              err_evt = 1'b1;
              st_n    = FS_WAIT;
            end
          end
          FS_BODY, FS_RESP: begin
            if (cls == SC_SHORT || cls == SC_LONG) begin
              bit_en = 1'b1;
            end else if (cls == SC_BRK) begin
              st_n = FS_WAIT;
            end else if (cls == SC_EOD || cls == SC_EOF) begin
              if (!aligned || (empty && st_q == FS_RESP)) begin
                err_evt = 1'b1;
                st_n    = abort_to;
              end else if (empty) begin
                crc_evt = 1'b1;
                st_n    = abort_to;
              end else if ((st_q == FS_BODY || resp_crc_q) && crc_res != CRC_GOOD) begin
                crc_evt = 1'b1;
                st_n    = abort_to;
              end else if (st_q == FS_BODY) begin
                if (cls == SC_EOD) begin
                  st_n = FS_POSTEOD;
                end else begin
                  st_n        = FS_IDLE;
                  gap_short_n = (sym_width < T_IFS);
                end
              end else begin
                st_n        = (cls == SC_EOD) ? FS_WAIT : FS_IDLE;
                gap_short_n = 1'b0;
              end
            end else begin
              err_evt = 1'b1;
              st_n    = FS_WAIT;
            end
          end
          FS_POSTEOD: begin
            if (cls == SC_SHORT || cls == SC_LONG) begin
              st_n        = FS_RESP;
              resp_crc_n  = (cls == SC_LONG);
              shift_start = 1'b1;
            end else if (cls == SC_BRK) begin
              st_n = FS_WAIT;
            end else begin
              err_evt = 1'b1;
              st_n    = abort_to;
            end
          end
          default: st_n = FS_WAIT;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= FS_WAIT;
      gap_short_q <= 1'b0;
      resp_crc_q  <= 1'b0;
      last_resp_q <= 1'b0;
      err_flag    <= 1'b0;
      crc_flag    <= 1'b0;
    end else begin
      st_q        <= st_n;
      gap_short_q <= gap_short_n;
      resp_crc_q  <= resp_crc_n;
      if (bit_en) last_resp_q <= (st_q == FS_RESP);
      if (err_evt)      err_flag <= 1'b1;
      else if (clr_err) err_flag <= 1'b0;
      if (crc_evt)      crc_flag <= 1'b1;
      else if (clr_crc) crc_flag <= 1'b0;
    end
  end

  assign rx_ifr = rx_valid && last_resp_q;

  // R13
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !clr_err |=> err_flag);

  // R13
  crc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_flag && !clr_crc |=> crc_flag);

  // R9
  crc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_flag) |-> $past(crc_evt));

  // R11
  abort_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt || crc_evt) |=> (st_q == FS_WAIT || st_q == FS_IDLE));

  // R11
  wait_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_WAIT && sym_valid && !ev_noise && !echo_fail) |-> !err_evt && !crc_evt);

  // R2
  noise_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_noise && !nxt) |=> err_flag && st_q == FS_WAIT);

  // R3
  byte_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(st_q == FS_BODY || st_q == FS_RESP));

  // R11
  brk_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && cls == SC_BRK && !nxt && !echo_fail && st_q != FS_WAIT) |=> st_q == FS_WAIT);

  // R12
  echo_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (echo_fail && !nxt) |=> err_flag);

endmodule

// File: tb/vpw_frame_checker_tb.sv
module vpw_frame_checker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W_SHORT = 64, W_LONG = 128, W_SOF = 200, W_EOD = 200,
                 W_EOF = 300, W_BRK = 400, W_NOISE = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_valid = 1'b0, sym_level = 1'b0;
  logic [9:0] sym_width = '0;
  logic       echo_fail = 1'b0, nxt = 1'b0, clr_err = 1'b0, clr_crc = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_valid, rx_ifr, err_flag, crc_flag;

  int n_chk = 0, n_bad = 0;
  logic [8:0] exp_q[$];
  logic cur_lvl;
  logic [7:0] run_crc;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpw_frame_checker dut_i (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_level(sym_level),
    .sym_width(sym_width), .echo_fail(echo_fail), .nxt(nxt),
    .clr_err(clr_err), .clr_crc(clr_crc), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .rx_ifr(rx_ifr), .err_flag(err_flag), .crc_flag(crc_flag)
  );

  // byte-at-a-time formulation of the check byte
  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h1D) : (r << 1);
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // monitor: pops the scoreboard as bytes come out
  always @(negedge clk) begin
    if (rx_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R3/R11 unexpected byte actual=%0h expected=none", {rx_ifr, rx_byte});
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check("R3 byte", {rx_ifr, rx_byte}, e);
      end
    end
  end

  task automatic sym(input logic lvl, input int w);
    @(negedge clk);
    sym_valid = 1'b1; sym_level = lvl; sym_width = 10'(w);
    @(negedge clk);
    sym_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic sof();
    sym(1'b1, W_SOF);
    cur_lvl = 1'b0;
    run_crc = 8'hFF;
  endtask

  task automatic bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      logic v;
      v = b[7-i];
      sym(cur_lvl, (v ^ cur_lvl) ? W_LONG : W_SHORT);
      cur_lvl = ~cur_lvl;
    end
  endtask

  task automatic tx_byte(input logic [7:0] b, input logic ifr, input bit expect_it);
    if (expect_it) exp_q.push_back({ifr, b});
    run_crc = ref_crc(run_crc, b);
    bits(b, 8);
  endtask

  task automatic tx_check(input logic ifr, input bit expect_it, input bit corrupt);
    logic [7:0] c;
    c = ~run_crc ^ (corrupt ? 8'h01 : 8'h00);
    tx_byte(c, ifr, expect_it);
  endtask

  task automatic body(input bit expect_it, input bit corrupt);
    sof();
    tx_byte(8'h68, 1'b0, expect_it);
    tx_byte(8'h6A, 1'b0, expect_it);
    tx_byte(8'hF1, 1'b0, expect_it);
    tx_check(1'b0, expect_it, corrupt);
  endtask

  task automatic nb(input int w);
    sym(1'b1, w);
    cur_lvl = 1'b0;
    run_crc = 8'hFF;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1; @(negedge clk); s = 1'b0; @(negedge clk);
  endtask

  task automatic flags(input string req, input logic e, input logic c);
    repeat (2) @(negedge clk);
    check({req, " err"}, err_flag, e);
    check({req, " crc"}, crc_flag, c);
    check({req, " queue drained"}, exp_q.size(), 0);
    clr_err = 1'b1; clr_crc = 1'b1;
    @(negedge clk);
    clr_err = 1'b0; clr_crc = 1'b0;
    sym(1'b0, W_EOF);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 err", err_flag, 0);
    check("R1 crc", crc_flag, 0);
    check("R1 valid", rx_valid, 0);
    rst_n = 1'b1;
    // R1 frame before first idle is discarded
    body(1'b0, 1'b0);
    repeat (2) @(negedge clk);
    check("R1 no flag err", err_flag, 0);
    sym(1'b0, W_EOF);

    // R3 R9 good frame without response
    body(1'b1, 1'b0);
    sym(1'b0, W_EOF);
    flags("R9 good", 0, 0);

    // R9 bad body check byte
    body(1'b1, 1'b1);
    sym(1'b0, W_EOF);
    flags("R9 bad", 0, 1);

    // R8 zero length
    sof();
    sym(1'b0, W_EOF);
    flags("R8", 0, 1);

    // R5 incomplete byte
    sof();
    bits(8'hA4, 6);
    sym(1'b0, W_EOF);
    flags("R5", 1, 0);

    // R4 illegal symbol mid message
    sof();
    tx_byte(8'h3C, 1'b0, 1'b1);
    bits(8'h00, 1);
    sym(1'b1, 180);
    flags("R4", 1, 0);

    // R6 bad SOF width in idle
    sym(1'b1, W_LONG);
    flags("R6 sof", 1, 0);

    // R6 bad normalisation bit width
    body(1'b1, 1'b0);
    sym(1'b0, W_EOD);
    sym(1'b1, W_SOF);
    flags("R6 nb", 1, 0);

    // R7 SOF too soon after a frame with no response
    body(1'b1, 1'b0);
    sym(1'b0, 250);
    sof();
    flags("R7", 1, 0);

    // R10 checked response, good and bad
    body(1'b1, 1'b0);
    sym(1'b0, W_EOD);
    nb(W_LONG);
    tx_byte(8'h33, 1'b1, 1'b1);
    tx_check(1'b1, 1'b1, 1'b0);
    sym(1'b0, W_EOF);
    flags("R10 good", 0, 0);
    body(1'b1, 1'b0);
    sym(1'b0, W_EOD);
    nb(W_LONG);
    tx_byte(8'h33, 1'b1, 1'b1);
    tx_check(1'b1, 1'b1, 1'b1);
    sym(1'b0, W_EOF);
    flags("R10 bad", 0, 1);

    // R9 bad body: attached response yields nothing
    body(1'b1, 1'b1);
    sym(1'b0, W_EOD);
    nb(W_LONG);
    tx_byte(8'h44, 1'b1, 1'b0);
    tx_check(1'b1, 1'b0, 1'b0);
    sym(1'b0, W_EOF);
    flags("R9 ifr drop", 0, 1);

    // R11 unchecked response, then a second response is dropped
    body(1'b1, 1'b0);
    sym(1'b0, W_EOD);
    nb(W_SHORT);
    tx_byte(8'h5A, 1'b1, 1'b1);
    sym(1'b0, W_EOD);
    nb(W_SHORT);
    tx_byte(8'hC3, 1'b1, 1'b0);
    sym(1'b0, W_EOF);
    flags("R11 second nb", 0, 0);
    body(1'b1, 1'b0);
    sym(1'b0, W_EOF);
    flags("R11 recovered", 0, 0);

    // R11 break mid frame
    sof();
    tx_byte(8'h11, 1'b0, 1'b1);
    bits(8'h00, 1);
    sym(1'b1, W_BRK);
    cur_lvl = 1'b0;
    bits(8'hFF, 8);
    flags("R11 break", 0, 0);

    // R11 nxt then discarded frame, R2 noise during wait
    pulse(nxt);
    body(1'b0, 1'b0);
    repeat (2) @(negedge clk);
    check("R11 nxt err", err_flag, 0);
    sym(1'b0, W_NOISE);
    flags("R2 noise wait", 1, 0);

    // R2 noise mid frame
    sof();
    bits(8'h80, 3);
    sym(cur_lvl, W_NOISE);
    flags("R2 noise body", 1, 0);

    // R12 echo fail, R13 set wins over clear
    pulse(echo_fail);
    repeat (2) @(negedge clk);
    check("R12 err", err_flag, 1);
    @(negedge clk);
    echo_fail = 1'b1; clr_err = 1'b1;
    @(negedge clk);
    echo_fail = 1'b0; clr_err = 1'b0;
    @(negedge clk);
    check("R13 set wins", err_flag, 1);
    pulse(clr_err);
    check("R13 cleared", err_flag, 0);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule